// File: doc/BRIEF.md
# NAND command and address sequencer

The sequencer turns one request for a flash read, page program or change-read-column operation into an ordered series of byte cycles on a byte-wide flash bus. Every byte is marked as either a command byte or an address byte. The caller gives a one-cycle start pulse together with an operation code, a column address, a row address and a set of configuration fields. The block then sends, one byte per cycle:

- an optional prefix command, used for TLC parts that run in pseudo-SLC mode;
- the first command byte of the operation;
- the column and row address bytes;
- the closing command byte.

The number of row bytes is set by a configuration field. For change read column, a control bit chooses between sending the column address alone or the full column-plus-row address. The prefix byte is either one of two fixed values or a programmable value.

Chip enable goes low for the whole operation. After the operation it is released, unless the hold bit was set, in which case it stays low so that the next operation runs inside the same selection. A done flag pulses once after the last byte. All configuration and address inputs are captured on the accepted start pulse, so the caller may change them while the operation runs. Electrical pin timing and data transfer belong to neighbouring logic.

Top module: `nandseq`

## Requirements
- R1: After reset `ceN` is 1, and `busValid` and `done` are 0.
- R2: A read (`opType` 00) sends the following sequence: command 00h, then two column bytes with the least significant byte first, then the row bytes with the least significant byte first, then command 30h. The first byte appears in the cycle after the start pulse is sampled. Each byte lasts exactly one cycle with `busValid` high, and `busIsCmd` is 1 for command bytes and 0 for address bytes.
- R3: A program (`opType` 01) sends command 80h, the column and row bytes, and then command 10h.
- R4: `cfgRowWidth` sets the number of row bytes: 00 gives three, 01 gives two, 10 gives four, and the reserved code 11 gives three.
- R5: A change read column (`opType` 10) sends command 05h, then the address bytes, then command E0h. The address bytes are the two column bytes alone when `cfgChrcFull` is 0, or the column bytes followed by the row bytes when it is 1.
- R6: When `cfgPrefixEn` is 1, one extra command byte is sent before the first command byte. `cfgPrefixSel` chooses its value: 00 gives A2h, 01 gives 3Bh, 10 gives `cfgPrefixProg`, and the reserved code 11 gives A2h.
- R7: `cfgPrefixProg` has no effect unless `cfgPrefixSel` is 10, and no prefix byte is sent when `cfgPrefixEn` is 0.
- R8: `done` is high for exactly one cycle, the cycle right after the closing command byte.
- R9: `ceN` is 0 on every byte cycle. In the `done` cycle `ceN` is 1 if the captured `cfgCeHold` was 0. If it was 1, `ceN` stays 0 until an operation captured with `cfgCeHold` 0 finishes.
- R10: A start pulse that arrives while an operation is in progress is ignored. Input changes after the accepted start do not alter the byte stream. No byte is sent in the cycle after `done` unless a new start was given.
- R11: `opType` 11 is reserved and is handled as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse |
| opType | input | 2 | 00 read, 01 program, 10 change read column, 11 treated as read |
| colAddr | input | 16 | Column address, sent as two bytes |
| rowAddr | input | 32 | Row address; only the low bytes selected by `cfgRowWidth` are sent |
| cfgPrefixEn | input | 1 | Send a prefix command byte first |
| cfgPrefixSel | input | 2 | Prefix value select |
| cfgPrefixProg | input | 8 | Programmable prefix value |
| cfgRowWidth | input | 2 | Row byte count code |
| cfgChrcFull | input | 1 | Change read column sends the full address |
| cfgCeHold | input | 1 | Keep chip enable low after the operation |
| busByte | output | 8 | Byte on the flash bus |
| busValid | output | 1 | Byte strobe |
| busIsCmd | output | 1 | 1 for a command byte, 0 for an address byte |
| ceN | output | 1 | Chip enable, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: two column bytes and room for four row bytes. This means the longest address phase, six bytes, can be driven, along with every row width code, the reserved one included. Directed scenarios cover each operation code, each prefix select code, and both change-read-column forms. A start pulse with altered inputs is injected in the middle of an operation. The hold setting is carried across two back-to-back operations so that chip enable can be followed between them.

// File: rtl/nandseq_pkg.sv
package nandseq_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'b00,
    OP_PROG = 2'b01,
    OP_CRC  = 2'b10,
    OP_RSVD = 2'b11
  } opKind_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;
    logic emitPrefix;
    logic emitCmd1;
    logic emitAddr;
    logic emitCmd2;
  } seqStrobe_t;

  localparam logic [7:0] CMD_READ_1 = 8'h00;
  localparam logic [7:0] CMD_READ_2 = 8'h30;
  localparam logic [7:0] CMD_PROG_1 = 8'h80;
  localparam logic [7:0] CMD_PROG_2 = 8'h10;
  localparam logic [7:0] CMD_CRC_1  = 8'h05;
  localparam logic [7:0] CMD_CRC_2  = 8'hE0;
  localparam logic [7:0] PFX_FIXED_A = 8'hA2;
  localparam logic [7:0] PFX_FIXED_B = 8'h3B;

  // Row byte count from the width code (reserved code falls back to three)
  function automatic logic [2:0] rowBytesOf(input logic [1:0] code);
    case (code)
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/nandseq_datapath.sv
module nandseq_datapath
  import nandseq_pkg::*;
#(
  parameter int COL_BYTES     = 2,
  parameter int ROW_BYTES_MAX = 4,
  parameter int IDX_W         = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strobe,
  input  logic [IDX_W-1:0]           addrIdx,
  input  logic [1:0]                 opType,
  input  logic [8*COL_BYTES-1:0]     colAddr,
  input  logic [8*ROW_BYTES_MAX-1:0] rowAddr,
  input  logic [1:0]                 cfgPrefixSel,
  input  logic [7:0]                 cfgPrefixProg,
  input  logic [1:0]                 cfgRowWidth,
  input  logic                       cfgChrcFull,
  input  logic                       cfgCeHold,
  output logic [IDX_W-1:0]           addrCount,
  output logic                       ceHoldQ,
  output logic [7:0]                 busByte,
  output logic                       busValid,
  output logic                       busIsCmd
);

  localparam int ADDR_MAX = COL_BYTES + ROW_BYTES_MAX;
  localparam int COL_W    = 8 * COL_BYTES;
  localparam int ROW_W    = 8 * ROW_BYTES_MAX;

  opKind_e          opQ;
  logic [COL_W-1:0] colQ;
  logic [ROW_W-1:0] rowQ;
  logic [1:0]       prefixSelQ;
  logic [7:0]       prefixProgQ;
  logic [1:0]       rowWidthQ;
  logic             chrcFullQ;

  // Capture every operand on the accepted start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ         <= OP_READ;
      colQ        <= '0;
      rowQ        <= '0;
      prefixSelQ  <= 2'b00;
      prefixProgQ <= 8'h00;
      rowWidthQ   <= 2'b00;
      chrcFullQ   <= 1'b0;
      ceHoldQ     <= 1'b0;
    end else if (strobe.capture) begin
      opQ         <= opKind_e'(opType);
      colQ        <= colAddr;
      rowQ        <= rowAddr;
      prefixSelQ  <= cfgPrefixSel;
      prefixProgQ <= cfgPrefixProg;
      rowWidthQ   <= cfgRowWidth;
      chrcFullQ   <= cfgChrcFull;
      ceHoldQ     <= cfgCeHold;
    end
  end

  // Address bytes in send order: column first, each LSB first
  logic [8*ADDR_MAX-1:0] addrVec;
  logic [7:0]            addrByte [ADDR_MAX];
  assign addrVec = {rowQ, colQ};

  for (genvar k = 0; k < ADDR_MAX; k++) begin : g_addrByte
    assign addrByte[k] = addrVec[8*k +: 8];
  end

  logic [7:0] addrSel;
  always_comb begin
    addrSel = 8'h00;
    for (int k = 0; k < ADDR_MAX; k++) begin
      if (addrIdx == IDX_W'(k)) addrSel = addrByte[k];
    end
  end

  // Number of address bytes for the captured operation
  logic [IDX_W-1:0] rowCount;
  assign rowCount = IDX_W'(rowBytesOf(rowWidthQ));

  always_comb begin
    if (opQ == OP_CRC && !chrcFullQ) addrCount = IDX_W'(COL_BYTES);
    else                             addrCount = IDX_W'(COL_BYTES) + rowCount;
  end

  // Command bytes
  logic [7:0] cmdFirst, cmdLast, prefixByte;

  always_comb begin
    case (opQ)
      OP_PROG: begin cmdFirst = CMD_PROG_1; cmdLast = CMD_PROG_2; end
      OP_CRC:  begin cmdFirst = CMD_CRC_1;  cmdLast = CMD_CRC_2;  end
      default: begin cmdFirst = CMD_READ_1; cmdLast = CMD_READ_2; end
    endcase
  end

  always_comb begin
    case (prefixSelQ)
      2'b01:   prefixByte = PFX_FIXED_B;
      2'b10:   prefixByte = prefixProgQ;
      default: prefixByte = PFX_FIXED_A;
    endcase
  end

  // Bus byte selection
  always_comb begin
    busByte = 8'h00;
    if (strobe.emitPrefix)    busByte = prefixByte;
    else if (strobe.emitCmd1) busByte = cmdFirst;
    else if (strobe.emitAddr) busByte = addrSel;
    else if (strobe.emitCmd2) busByte = cmdLast;
  end

  assign busIsCmd = strobe.emitPrefix | strobe.emitCmd1 | strobe.emitCmd2;
  assign busValid = busIsCmd | strobe.emitAddr;

endmodule

// File: rtl/nandseq_ctrl.sv
module nandseq_ctrl
  import nandseq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cfgPrefixEn,
  input  logic [IDX_W-1:0] addrCount,
  input  logic             ceHoldQ,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] addrIdx,
  output logic             ceN,
  output logic             done
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREFIX,
    ST_CMD1,
    ST_ADDR,
    ST_CMD2
  } seqState_e;

  seqState_e state, stateNext;
  logic      lastAddr;

  assign lastAddr = (addrIdx == addrCount - IDX_W'(1));

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (start) stateNext = cfgPrefixEn ? ST_PREFIX : ST_CMD1;
      ST_PREFIX: stateNext = ST_CMD1;
      ST_CMD1:   stateNext = ST_ADDR;
      ST_ADDR:   if (lastAddr) stateNext = ST_CMD2;
      ST_CMD2:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe            = '0;
    strobe.capture    = (state == ST_IDLE) && start;
    strobe.emitPrefix = (state == ST_PREFIX);
    strobe.emitCmd1   = (state == ST_CMD1);
    strobe.emitAddr   = (state == ST_ADDR);
    strobe.emitCmd2   = (state == ST_CMD2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      addrIdx <= '0;
      ceN     <= 1'b1;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_CMD2);
      if (state == ST_ADDR) addrIdx <= addrIdx + IDX_W'(1);
      else                  addrIdx <= '0;
      if (strobe.capture)        ceN <= 1'b0;
      else if (state == ST_CMD2) ceN <= ~ceHoldQ;
    end
  end

endmodule

// File: rtl/nandseq.sv
module nandseq
  import nandseq_pkg::*;
#(
  parameter int COL_BYTES     = 2,
  parameter int ROW_BYTES_MAX = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [1:0]                 opType,
  input  logic [8*COL_BYTES-1:0]     colAddr,
  input  logic [8*ROW_BYTES_MAX-1:0] rowAddr,
  input  logic                       cfgPrefixEn,
  input  logic [1:0]                 cfgPrefixSel,
  input  logic [7:0]                 cfgPrefixProg,
  input  logic [1:0]                 cfgRowWidth,
  input  logic                       cfgChrcFull,
  input  logic                       cfgCeHold,
  output logic [7:0]                 busByte,
  output logic                       busValid,
  output logic                       busIsCmd,
  output logic                       ceN,
  output logic                       done
);

  localparam int ADDR_MAX = COL_BYTES + ROW_BYTES_MAX;
  localparam int IDX_W    = $clog2(ADDR_MAX + 1);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] addrIdx;
  logic [IDX_W-1:0] addrCount;
  logic             ceHoldQ;

  nandseq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .cfgPrefixEn (cfgPrefixEn),
    .addrCount   (addrCount),
    .ceHoldQ     (ceHoldQ),
    .strobe      (strobe),
    .addrIdx     (addrIdx),
    .ceN         (ceN),
    .done        (done)
  );

  nandseq_datapath #(
    .COL_BYTES     (COL_BYTES),
    .ROW_BYTES_MAX (ROW_BYTES_MAX),
    .IDX_W         (IDX_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .addrIdx       (addrIdx),
    .opType        (opType),
    .colAddr       (colAddr),
    .rowAddr       (rowAddr),
    .cfgPrefixSel  (cfgPrefixSel),
    .cfgPrefixProg (cfgPrefixProg),
    .cfgRowWidth   (cfgRowWidth),
    .cfgChrcFull   (cfgChrcFull),
    .cfgCeHold     (cfgCeHold),
    .addrCount     (addrCount),
    .ceHoldQ       (ceHoldQ),
    .busByte       (busByte),
    .busValid      (busValid),
    .busIsCmd      (busIsCmd)
  );

endmodule

// File: rtl/nandseq_checker.sv
module nandseq_checker (
  input logic clk,
  input logic rstN,
  input logic busValid,
  input logic busIsCmd,
  input logic ceN,
  input logic done
);

  AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busValid && busIsCmd)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_CE_LOW_ON_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !ceN); // R9

  AST_CE_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ceN) |-> done); // R9

  AST_NO_BYTE_IN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busValid); // R10

endmodule

bind nandseq nandseq_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busIsCmd (busIsCmd),
  .ceN      (ceN),
  .done     (done)
);

// File: tb/nandseq_test.sv
`timescale 1ns/1ps
module nandseq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opType = 2'b00;
  logic [15:0] colAddr = '0;
  logic [31:0] rowAddr = '0;
  logic        cfgPrefixEn = 1'b0;
  logic [1:0]  cfgPrefixSel = 2'b00;
  logic [7:0]  cfgPrefixProg = 8'h00;
  logic [1:0]  cfgRowWidth = 2'b00;
  logic        cfgChrcFull = 1'b0;
  logic        cfgCeHold = 1'b0;
  logic [7:0]  busByte;
  logic        busValid, busIsCmd, ceN, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  nandseq uut (
    .clk(clk), .rstN(rstN), .start(start), .opType(opType),
    .colAddr(colAddr), .rowAddr(rowAddr), .cfgPrefixEn(cfgPrefixEn),
    .cfgPrefixSel(cfgPrefixSel), .cfgPrefixProg(cfgPrefixProg),
    .cfgRowWidth(cfgRowWidth), .cfgChrcFull(cfgChrcFull),
    .cfgCeHold(cfgCeHold), .busByte(busByte), .busValid(busValid),
    .busIsCmd(busIsCmd), .ceN(ceN), .done(done)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Runs one operation and compares every byte cycle with the expected stream
  task automatic runOp(input string tag, input logic [1:0] op, input logic [15:0] col,
                       input logic [31:0] row, input logic pre, input logic [1:0] sel,
                       input logic [7:0] prog, input logic [1:0] rw, input logic full,
                       input logic hold, input bit disturb);
    logic [8:0] exp [16];
    int n = 0;
    int rows;
    logic [7:0] c1, c2, pfx;
    case (op)
      2'b01: begin c1 = 8'h80; c2 = 8'h10; end
      2'b10: begin c1 = 8'h05; c2 = 8'hE0; end
      default: begin c1 = 8'h00; c2 = 8'h30; end
    endcase
    case (sel)
      2'b01: pfx = 8'h3B;
      2'b10: pfx = prog;
      default: pfx = 8'hA2;
    endcase
    case (rw)
      2'b01: rows = 2;
      2'b10: rows = 4;
      default: rows = 3;
    endcase
    if (op == 2'b10 && !full) rows = 0;
    if (pre) begin exp[n] = {1'b1, pfx}; n++; end
    exp[n] = {1'b1, c1}; n++;
    exp[n] = {1'b0, col[7:0]}; n++;
    exp[n] = {1'b0, col[15:8]}; n++;
    for (int i = 0; i < rows; i++) begin exp[n] = {1'b0, row[8*i +: 8]}; n++; end
    exp[n] = {1'b1, c2}; n++;

    @(negedge clk);
    opType = op; colAddr = col; rowAddr = row; cfgPrefixEn = pre;
    cfgPrefixSel = sel; cfgPrefixProg = prog; cfgRowWidth = rw;
    cfgChrcFull = full; cfgCeHold = hold; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      check({tag, " valid"}, {15'd0, busValid}, 16'd1);
      check({tag, " byte"}, {7'd0, busIsCmd, busByte}, {7'd0, exp[i]});
      check("R9 ceN low on byte", {15'd0, ceN}, 16'd0);
      if (disturb && i == 1) begin
        start = 1'b1; opType = 2'b01; colAddr = 16'hFFFF; rowAddr = '1;
        cfgPrefixEn = ~pre; cfgRowWidth = 2'b10; cfgChrcFull = ~full;
        cfgPrefixSel = 2'b01; cfgCeHold = ~hold;
      end
      if (disturb && i == 2) start = 1'b0;
      @(negedge clk);
    end
    check("R8 done after last byte", {15'd0, done}, 16'd1);
    check("R8 no byte in done cycle", {15'd0, busValid}, 16'd0);
    check("R9 ceN in done cycle", {15'd0, ceN}, {15'd0, ~hold});
    @(negedge clk);
    check("R8 done single cycle", {15'd0, done}, 16'd0);
    check("R10 idle after done", {15'd0, busValid}, 16'd0);
    check("R9 ceN after done", {15'd0, ceN}, {15'd0, ~hold});
  endtask

  task automatic testReset();
    check("R1 ceN reset", {15'd0, ceN}, 16'd1);
    check("R1 valid reset", {15'd0, busValid}, 16'd0);
    check("R1 done reset", {15'd0, done}, 16'd0);
  endtask

  task automatic testRead();
    runOp("R2 read 3 row", 2'b00, 16'h1234, 32'hA1B2C3D4, 0, 2'b00, 8'h00, 2'b00, 0, 0, 0);
    runOp("R11 op 11 as read", 2'b11, 16'hBEEF, 32'h01020304, 0, 2'b00, 8'h00, 2'b00, 0, 0, 0);
  endtask

  task automatic testProgWidths();
    runOp("R3 program", 2'b01, 16'h5566, 32'h11223344, 0, 2'b00, 8'h00, 2'b00, 0, 0, 0);
    runOp("R4 width 01", 2'b01, 16'h5566, 32'h11223344, 0, 2'b00, 8'h00, 2'b01, 0, 0, 0);
    runOp("R4 width 10", 2'b00, 16'h789A, 32'hCAFEF00D, 0, 2'b00, 8'h00, 2'b10, 0, 0, 0);
    runOp("R4 width 11", 2'b00, 16'h789A, 32'hCAFEF00D, 0, 2'b00, 8'h00, 2'b11, 0, 0, 0);
  endtask

  task automatic testChrc();
    runOp("R5 column only", 2'b10, 16'h0A0B, 32'hDEADBEEF, 0, 2'b00, 8'h00, 2'b10, 0, 0, 0);
    runOp("R5 full address", 2'b10, 16'h0A0B, 32'hDEADBEEF, 0, 2'b00, 8'h00, 2'b01, 1, 0, 0);
  endtask

  task automatic testPrefix();
    runOp("R6 prefix sel 00", 2'b00, 16'h1111, 32'h22222222, 1, 2'b00, 8'h5C, 2'b00, 0, 0, 0);
    runOp("R6 prefix sel 01", 2'b01, 16'h1111, 32'h22222222, 1, 2'b01, 8'h5C, 2'b01, 0, 0, 0);
    runOp("R6 prefix sel 10", 2'b00, 16'h1111, 32'h22222222, 1, 2'b10, 8'h5C, 2'b00, 0, 0, 0);
    runOp("R7 prog unused sel 11", 2'b10, 16'h1111, 32'h22222222, 1, 2'b11, 8'h5C, 2'b00, 1, 0, 0);
    runOp("R7 prefix disabled", 2'b00, 16'h3333, 32'h44444444, 0, 2'b10, 8'h5C, 2'b00, 0, 0, 0);
  endtask

  task automatic testHold();
    runOp("R9 held op", 2'b00, 16'h0102, 32'h03040506, 0, 2'b00, 8'h00, 2'b00, 0, 1, 0);
    repeat (3) @(negedge clk);
    check("R9 ceN held between ops", {15'd0, ceN}, 16'd0);
    runOp("R9 release op", 2'b01, 16'h0102, 32'h03040506, 0, 2'b00, 8'h00, 2'b01, 0, 0, 0);
  endtask

  task automatic testBusy();
    runOp("R10 start while busy", 2'b00, 16'h4321, 32'h87654321, 1, 2'b00, 8'h00, 2'b00, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRead();
    testProgWidths();
    testChrc();
    testPrefix();
    testHold();
    testBusy();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule